// File: doc/BRIEF.md
# Multi-channel edge timestamp recorder

This block monitors a bank of 64 digital inputs and logs the moment each selected input changes level. Every channel can be logically inverted and can independently log rising and falling transitions of its (inverted) level. A logged transition becomes one 32-bit word holding a free-running 24-bit cycle count, the 6-bit channel index and a polarity flag. Words go into a first-in first-out store that a host drains through a small register window.

Transitions detected on several channels in one cycle are held as a group in a short pending queue. They are then written one per cycle, lowest channel first, all carrying the timestamp of the cycle in which they were seen. If either the pending queue or the output store has no room, the transition is discarded and a sticky loss flag goes high. Everything runs on one clock.

Top module: `edge_ts_capture`

## Requirements
- R1: After a synchronous active-low reset, all six mask registers read 0, the status word reads 0x4000_0000 (empty, count 0), the head word reads 0 and `ovf` is 0.
- R2: Writes with `wr_en` load mask registers: address 0/1 = invert for channels 31..0 / 63..32, 2/3 = rising-edge enable for the low / high half, 4/5 = falling-edge enable for the low / high half, bit n of a half mapping to channel n (+32 for the high half). All six read back at the same address. Writes to addresses 6 and 7 change nothing.
- R3: A low-to-high change of the inverted level on a channel with its rising enable set yields a word with bit 0 = 1, bits 6:1 = channel, bits 30:7 = timestamp, bit 31 = 0. The word is at the head of an empty store at the second clock edge after the input changes.
- R4: A high-to-low change of the inverted level on a channel with its falling enable set yields the same format with bit 0 = 0.
- R5: Inversion is applied before detection, so a rising pin on an inverted channel is logged as a falling transition.
- R6: Transitions whose polarity is disabled are not logged, and inputs that hold steady log nothing.
- R7: Transitions seen in one cycle on several channels are written on consecutive cycles in ascending channel order, all with the same timestamp.
- R8: The status word (address 6) is {full, empty, 6'b0, 24-bit fill count}.
- R9: Address 7 returns the oldest stored word, or 0 when empty. A `pop` pulse removes one word, and a `pop` while empty has no effect.
- R10: A word arriving while the store is full (16 words), or a new group arriving while the pending queue holds 4 groups, is dropped. `ovf` then rises and stays high until reset.
- R11: The timestamp is 0 in the first cycle after reset and increments by one per cycle, modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 64 | Monitored channel levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| pop | input | 1 | Remove the head word from the store |
| ovf | output | 1 | Sticky loss flag |

## Verification
A level change driven between clock edges is sampled at the next edge. That edge creates the pending group, and the word reaches the store one edge later. The head and status therefore change two edges after the stimulus, and later words of the same group follow one edge apart. `pop`, mask writes and `ovf` act at the first edge. The bench drives inputs on falling edges and compares status, head and `ovf` against a queue-based model after every falling edge. Its directed field checks are placed at exactly those edge counts.

// File: rtl/ets_pkg.sv
// Package: shared widths, register addresses and word packing for the
// edge timestamp recorder. Assumes 64 channels split into two 32-bit halves.
package ets_pkg;
    localparam int NUM_CH = 64;
    localparam int HALF_W = 32;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int TS_W   = 24;
    localparam int WORD_W = 32;
    localparam int CNT_FIELD_W = 24;

    typedef logic [NUM_CH-1:0] chvec_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ADDR_INV_LO  = 3'd0,
        ADDR_INV_HI  = 3'd1,
        ADDR_RISE_LO = 3'd2,
        ADDR_RISE_HI = 3'd3,
        ADDR_FALL_LO = 3'd4,
        ADDR_FALL_HI = 3'd5,
        ADDR_STATUS  = 3'd6,
        ADDR_HEAD    = 3'd7
    } reg_addr_e;

    // Build a log word: {0, timestamp, channel, rising flag}
    function automatic word_t pack_word(logic [TS_W-1:0] ts, logic [CH_W-1:0] ch, logic rising);
        return {1'b0, ts, ch, rising};
    endfunction
endpackage

// File: rtl/ets_edge_detect.sv
// Edge detector: inverts each channel, compares it with last cycle's level,
// and reports enabled rising/falling transitions. During reset the history
// register takes the raw input (invert masks reset to zero), so no transition
// appears right after reset.
module ets_edge_detect
    import ets_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  chvec_t din,
    input  chvec_t inv,
    input  chvec_t rise_en,
    input  chvec_t fall_en,
    output chvec_t ev_mask,
    output chvec_t ev_rise
);
    chvec_t level, prev_q, ev_fall;

    // Polarity-corrected level and qualified transitions
    always_comb begin
        level   = din ^ inv;
        ev_rise = level & ~prev_q & rise_en;
        ev_fall = ~level & prev_q & fall_en;
        ev_mask = ev_rise | ev_fall;
    end

    // History of the corrected level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= din;
        else        prev_q <= level;
    end

    // R6: unchanged inputs and masks never produce a transition
    assert_steady_no_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(din) && $stable(inv)) |-> (ev_mask == '0));
endmodule

// File: rtl/ets_pend_queue.sv
// Pending queue: stores groups of same-cycle transitions (mask, polarity,
// timestamp) and emits one word per cycle, lowest channel of the head group
// first. A new group is dropped when DEPTH groups are held. DEPTH must be a
// power of two.
module ets_pend_queue
    import ets_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  chvec_t          push_mask,
    input  chvec_t          push_rise,
    input  logic [TS_W-1:0] push_ts,
    output logic            drop,
    output logic            out_valid,
    output word_t           out_word
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    chvec_t          q_mask [DEPTH];
    chvec_t          q_rise [DEPTH];
    logic [TS_W-1:0] q_ts   [DEPTH];
    logic [PW-1:0]   wp_q, rp_q;
    logic [CW-1:0]   cnt_q;
    logic [CH_W-1:0] sel;
    chvec_t          head_mask, rest_mask;
    logic            do_push, do_pop, have_new;

    // Lowest set channel of the head group and the mask left after it
    always_comb begin
        head_mask = q_mask[rp_q];
        sel = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (head_mask[i]) sel = CH_W'(i);
        end
        rest_mask = head_mask & ~(chvec_t'(1) << sel);
    end

    // Push/pop decisions and output word
    always_comb begin
        have_new  = |push_mask;
        out_valid = (cnt_q != '0);
        do_push   = have_new && (cnt_q != CW'(DEPTH));
        drop      = have_new && (cnt_q == CW'(DEPTH));
        do_pop    = out_valid && (rest_mask == '0);
        out_word  = pack_word(q_ts[rp_q], sel, q_rise[rp_q][sel]);
    end

    // Group storage, head consumption and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                q_mask[i] <= '0;
                q_rise[i] <= '0;
                q_ts[i]   <= '0;
            end
        end else begin
            if (do_push) begin
                q_mask[wp_q] <= push_mask;
                q_rise[wp_q] <= push_rise;
                q_ts[wp_q]   <= push_ts;
                wp_q         <= wp_q + 1'b1;
            end
            if (out_valid) q_mask[rp_q] <= rest_mask;
            if (do_pop)    rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    // R7: a held group always has at least one transition left to emit
    assert_head_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (q_mask[rp_q] != '0));
endmodule

// File: rtl/ets_fifo.sv
// Word store: circular buffer of DEPTH words (power of two). A write while
// full is refused and flagged; a pop while empty is ignored. Fullness is
// judged before the same-cycle pop.
module ets_fifo
    import ets_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  word_t                      wr_word,
    input  logic                       pop,
    output word_t                      head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty,
    output logic                       drop
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    word_t         mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_wr, do_rd;

    // Flags, accepted operations and head word
    always_comb begin
        count = cnt_q;
        full  = (cnt_q == CW'(DEPTH));
        empty = (cnt_q == '0);
        do_wr = wr_valid && !full;
        drop  = wr_valid && full;
        do_rd = pop && !empty;
        head  = empty ? '0 : mem[rp_q];
    end

    // Storage and pointer update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_wr) begin
                mem[wp_q] <= wr_word;
                wp_q      <= wp_q + 1'b1;
            end
            if (do_rd) rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_wr) - CW'(do_rd);
        end
    end

    // R9: popping an empty store with nothing arriving keeps it empty
    assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && (cnt_q == '0) && !wr_valid) |=> (cnt_q == '0));
    // R10: a full store that is not popped stays full
    assert_full_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);
endmodule

// File: rtl/edge_ts_capture.sv
// Top: mask registers, free-running timestamp, edge detector, pending
// queue and word store, plus the read window. Single clock domain; inputs
// are assumed already synchronous to clk.
module edge_ts_capture
    import ets_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int PEND_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] din,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              pop,
    output logic              ovf
);
    localparam int FCW = $clog2(FIFO_DEPTH + 1);

    chvec_t          inv_q, rise_q, fall_q, ev_mask, ev_rise;
    logic [TS_W-1:0] ts_q;
    logic            ovf_q, pend_drop, fifo_drop, pend_valid;
    logic            f_full, f_empty;
    logic [FCW-1:0]  f_count;
    word_t           pend_word, f_head, status;

    // Mask registers, timestamp counter and sticky loss flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            ts_q   <= '0;
            ovf_q  <= 1'b0;
        end else begin
            ts_q <= ts_q + 1'b1;
            if (pend_drop || fifo_drop) ovf_q <= 1'b1;
            if (wr_en) begin
                case (reg_addr_e'(wr_addr))
                    ADDR_INV_LO:  inv_q[HALF_W-1:0]       <= wr_data;
                    ADDR_INV_HI:  inv_q[NUM_CH-1:HALF_W]  <= wr_data;
                    ADDR_RISE_LO: rise_q[HALF_W-1:0]      <= wr_data;
                    ADDR_RISE_HI: rise_q[NUM_CH-1:HALF_W] <= wr_data;
                    ADDR_FALL_LO: fall_q[HALF_W-1:0]      <= wr_data;
                    ADDR_FALL_HI: fall_q[NUM_CH-1:HALF_W] <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    ets_edge_detect u_detect (
        .clk(clk), .rst_n(rst_n), .din(din), .inv(inv_q),
        .rise_en(rise_q), .fall_en(fall_q), .ev_mask(ev_mask), .ev_rise(ev_rise)
    );

    ets_pend_queue #(.DEPTH(PEND_DEPTH)) u_pend (
        .clk(clk), .rst_n(rst_n), .push_mask(ev_mask), .push_rise(ev_rise),
        .push_ts(ts_q), .drop(pend_drop), .out_valid(pend_valid), .out_word(pend_word)
    );

    ets_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_valid(pend_valid), .wr_word(pend_word),
        .pop(pop), .head(f_head), .count(f_count), .full(f_full),
        .empty(f_empty), .drop(fifo_drop)
    );

    // Read window multiplexer
    always_comb begin
        status = {f_full, f_empty, 6'b0, CNT_FIELD_W'(f_count)};
        case (reg_addr_e'(rd_addr))
            ADDR_INV_LO:  rd_data = inv_q[HALF_W-1:0];
            ADDR_INV_HI:  rd_data = inv_q[NUM_CH-1:HALF_W];
            ADDR_RISE_LO: rd_data = rise_q[HALF_W-1:0];
            ADDR_RISE_HI: rd_data = rise_q[NUM_CH-1:HALF_W];
            ADDR_FALL_LO: rd_data = fall_q[HALF_W-1:0];
            ADDR_FALL_HI: rd_data = fall_q[NUM_CH-1:HALF_W];
            ADDR_STATUS:  rd_data = status;
            default:      rd_data = f_head;
        endcase
        ovf = ovf_q;
    end

    // R10: the loss flag never clears outside reset
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
    // R11: timestamp advances by exactly one per cycle
    assert_ts_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ts_q == TS_W'($past(ts_q) + 1'b1)));
    // R8: the store never reports full and empty together
    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(f_full && f_empty));
endmodule

// File: tb/edge_ts_capture_bench.sv
`timescale 1ns/100ps
module edge_ts_capture_bench;
    localparam int FD = 16;
    localparam int PD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] din = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic        pop = 1'b0;
    wire  [31:0] rd_data;
    wire         ovf;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int since = 0;

    always #4 clk = ~clk;

    edge_ts_capture u_edge_ts_capture (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pop(pop), .ovf(ovf)
    );

    // ---------------- reference model ----------------
    bit [63:0] m_inv, m_rise, m_fall, m_prev, m_cur, m_r, m_f, m_tmp;
    bit [63:0] g_mask[$];
    bit [63:0] g_rise[$];
    int unsigned g_ts[$];
    bit [31:0] m_fifo[$];
    bit [31:0] m_word;
    bit        m_ovf;
    int unsigned m_ts;
    int pg, pf, mch;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_inv = '0; m_rise = '0; m_fall = '0; m_prev = din;
            g_mask.delete(); g_rise.delete(); g_ts.delete(); m_fifo.delete();
            m_ovf = 1'b0; m_ts = 0; since = 0;
        end else begin
            since++;
            pg = g_mask.size();
            pf = m_fifo.size();
            if (pop && pf > 0) void'(m_fifo.pop_front());
            if (pg > 0) begin
                m_tmp = g_mask[0];
                mch = 0;
                while (!m_tmp[mch]) mch++;
                m_word = {1'b0, m_ts_bits(g_ts[0]), mch[5:0], g_rise[0][mch]};
                if (pf < FD) m_fifo.push_back(m_word);
                else m_ovf = 1'b1;
                m_tmp[mch] = 1'b0;
                g_mask[0] = m_tmp;
                if (m_tmp == '0) begin
                    void'(g_mask.pop_front()); void'(g_rise.pop_front()); void'(g_ts.pop_front());
                end
            end
            m_cur = din ^ m_inv;
            m_r = m_cur & ~m_prev & m_rise;
            m_f = ~m_cur & m_prev & m_fall;
            if ((m_r | m_f) != '0) begin
                if (pg < PD) begin
                    g_mask.push_back(m_r | m_f); g_rise.push_back(m_r); g_ts.push_back(m_ts);
                end else m_ovf = 1'b1;
            end
            m_prev = m_cur;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_inv[31:0]   = wr_data;
                    3'd1: m_inv[63:32]  = wr_data;
                    3'd2: m_rise[31:0]  = wr_data;
                    3'd3: m_rise[63:32] = wr_data;
                    3'd4: m_fall[31:0]  = wr_data;
                    3'd5: m_fall[63:32] = wr_data;
                    default: ;
                endcase
            end
            m_ts = (m_ts + 1) & 32'h00FF_FFFF;
        end
    end

    function automatic bit [23:0] m_ts_bits(int unsigned t);
        return t[23:0];
    endfunction

    // ---------------- checking helpers ----------------
    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare();
        rd_addr = 3'd6; #0.2;
        check("R8 status vs model", rd_data,
              {m_fifo.size() == FD, m_fifo.size() == 0, 6'b0, 24'(m_fifo.size())});
        rd_addr = 3'd7; #0.2;
        check("R9 head vs model", rd_data, (m_fifo.size() > 0) ? m_fifo[0] : 32'h0);
        check("R10 ovf vs model", {31'b0, ovf}, {31'b0, m_ovf});
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a; #0.2;
        d = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pop1();
        pop = 1'b1;
        tick();
        pop = 1'b0;
    endtask

    task automatic drain();
        logic [31:0] s;
        for (int k = 0; k < 40; k++) begin
            rd(3'd6, s);
            if (s[30]) break;
            pop1();
        end
    endtask

    // Check one word's fields: channel, polarity, timestamp
    task automatic check_word(string tag, logic [31:0] w, int ch, bit rising, int ts);
        check({tag, " channel"}, {26'b0, w[6:1]}, ch);
        check({tag, " polarity"}, {31'b0, w[0]}, {31'b0, rising});
        check({tag, " timestamp"}, {8'b0, w[30:7]}, ts & 32'h00FF_FFFF);
        check({tag, " top bit"}, {31'b0, w[31]}, 32'h0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_err++;
            $display("FAIL watchdog expired (all requirements) actual %0d expected <20000", cyc);
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] w;
        int t0;

        do_reset();
        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), w);
            check("R1 mask reset", w, 32'h0);
        end
        rd(3'd6, w); check("R1 status reset", w, 32'h4000_0000);
        rd(3'd7, w); check("R1 head reset", w, 32'h0);
        check("R1 ovf reset", {31'b0, ovf}, 32'h0);

        // R2 register writes and read-back
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd5, 32'h0000_0000);
        wr(3'd1, 32'h0000_0000);
        rd(3'd2, w); check("R2 rise lo", w, 32'hFFFF_FFFF);
        rd(3'd3, w); check("R2 rise hi", w, 32'hFFFF_FFFF);
        rd(3'd4, w); check("R2 fall lo", w, 32'hFFFF_FFFF);
        rd(3'd5, w); check("R2 fall hi", w, 32'h0);
        wr(3'd6, 32'h1234_5678);
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd6, w); check("R2 write to status ignored", w, 32'h4000_0000);
        rd(3'd0, w); check("R2 inv lo untouched", w, 32'h0);

        // R3 rising edge on channel 5, R11 timestamp equals cycles since reset
        t0 = since;
        din[5] = 1'b1;
        tick(); tick();
        rd(3'd7, w); check_word("R3 rising ch5", w, 5, 1'b1, t0);
        pop1();

        // R4 falling edge on channel 5
        t0 = since;
        din[5] = 1'b0;
        tick(); tick();
        rd(3'd7, w); check_word("R4 falling ch5", w, 5, 1'b0, t0);
        pop1();

        // R5 inversion swaps polarity on channel 7
        wr(3'd0, 32'h0000_0080);
        tick(); tick();
        drain();
        t0 = since;
        din[7] = 1'b1;
        tick(); tick();
        rd(3'd7, w); check_word("R5 inverted pin rise", w, 7, 1'b0, t0);
        drain();

        // R6 falling disabled on channel 40, steady inputs log nothing
        din[40] = 1'b1; tick();
        din[40] = 1'b0; repeat (3) tick();
        rd(3'd6, w); check("R6 only rising logged", w, 32'h0000_0001);
        rd(3'd7, w); check("R6 ch40 rising word", {26'b0, w[6:1]}, 32'd40);
        drain();
        repeat (5) tick();
        rd(3'd6, w); check("R6 steady inputs log nothing", w, 32'h4000_0000);

        // R7 simultaneous channels 33, 3, 9: ascending order, shared timestamp
        t0 = since;
        din[33] = 1'b1; din[3] = 1'b1; din[9] = 1'b1;
        tick(); tick();
        rd(3'd7, w); check_word("R7 first", w, 3, 1'b1, t0);
        pop1();
        rd(3'd7, w); check_word("R7 second", w, 9, 1'b1, t0);
        pop1();
        rd(3'd7, w); check_word("R7 third", w, 33, 1'b1, t0);
        pop1();

        // R9 pop while empty
        pop1();
        rd(3'd6, w); check("R9 empty pop no effect", w, 32'h4000_0000);
        rd(3'd7, w); check("R9 empty head zero", w, 32'h0);

        // R10 store overflow: 20 transitions on channel 0, no pops
        for (int k = 0; k < 20; k++) begin
            din[0] = ~din[0];
            tick();
        end
        tick(); tick();
        rd(3'd6, w); check("R10 full status", w, 32'h8000_0010);
        check("R10 ovf set on full", {31'b0, ovf}, 32'h1);
        drain();
        check("R10 ovf sticky after drain", {31'b0, ovf}, 32'h1);

        // R10 pending-queue overflow after a fresh reset
        din = '0;
        do_reset();
        check("R1 ovf cleared by reset", {31'b0, ovf}, 32'h0);
        wr(3'd2, 32'h0000_00FF);
        wr(3'd4, 32'h0000_00FF);
        for (int k = 0; k < 6; k++) begin
            din[7:0] = ~din[7:0];
            tick();
        end
        rd(3'd6, w); check("R10 store not full", {31'b0, w[31]}, 32'h0);
        check("R10 ovf on pending queue full", {31'b0, ovf}, 32'h1);
        pop = 1'b1;
        repeat (40) tick();
        pop = 1'b0;
        rd(3'd6, w); check("R9 drained to empty", w, 32'h4000_0000);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule